// File: doc/BRIEF.md
# Compare-Capture Timer Channel

This block is one 16-bit timer channel with two capture/compare registers, A and B. The counter runs from a prescaled tick of the system clock. The prescaler divides by a power of two from 1 to 1024, and the tick can be taken on the rising phase, the falling phase or both phases of the divided clock. A match or a capture on either register can return the counter to zero. Without a clear source the counter runs freely and wraps at 0xFFFF, which sets an overflow flag.

Each of the two pins belongs to one register. A pin can be set up as a compare output that starts at a chosen level and goes low, goes high or toggles when its register matches. It can instead be a capture input that records the count on a rising edge, a falling edge or either edge. Software reaches the channel through a small write port and a combinational read port. Separate pulses start the counter, stop it and zero it. While the counter runs, new period and duty values wait in a buffer and move to the active registers at the next compare match of register A. This keeps each PWM cycle intact.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the count, control word, pin configuration, both registers and all flags read 0, the counter is stopped, and both pins are undriven and low. A `start` pulse sets `running` on the next edge. A `stop` pulse clears it, and `stop` wins if both arrive together.
- R2: Control bits [3:0] pick the divisor: code 0..6 divides by 2^code, code 7 by 256, code 8 by 1024, and any other code by 1. A free-running divider counts system clocks from reset, and the counter advances only on divider ticks while running.
- R3: Control bits [5:4] pick the tick phase for a divisor N > 1. Value 0 ticks when the low log2(N) divider bits are all ones. Value 1 ticks when those bits equal N/2-1. Values 2 and 3 tick on both. A divisor of 1 ticks on every clock.
- R4: Control bits [7:6] pick the clear source: 0 none, 1 register A, 2 register B. A compare match (count equals the register on a tick while running) or a capture on the selected register zeroes the counter on the next edge, so a match value V gives a period of V+1 ticks.
- R5: When the count is 0xFFFF on a tick and no clear occurs, the count wraps to 0 and the overflow flag (flag bit 0) is set.
- R6: Pin configuration bits [3:0] set pin A and bits [7:4] set pin B. Code 0 leaves the pin undriven. Codes 1/2/3 start low and then go low/high/toggle on match. Codes 4/5/6 start high with the same three actions. Codes 7/8/9 capture on rising/falling/either edge. Only codes 1..6 drive the pin.
- R7: A pin takes its initial level when its configuration is written, when the counter starts, and when the counter clears, unless its own register matched in that same cycle. In that case the match action applies.
- R8: While running, writes to register A (address 3) or B (address 4) go to a buffer and reads return the active value. Both buffers move to the active registers on the next compare match of A, except into a register in capture mode.
- R9: While stopped, a write to A loads it at once and zeroes the counter. A write to B loads it at once.
- R10: A write to the count (address 2) loads the count while stopped. While running the write is refused and the error flag (flag bit 3) is set. A `sw_reset` pulse zeroes the count on the next edge.
- R11: A capture input passes through a two-flop synchroniser and an edge detector. A pin edge presented before clock edge 1 latches, at edge 3, the count held after edge 2, and it sets the register's flag (bit 1 for A, bit 2 for B). Captures happen only while running, and edges of the unselected polarity are ignored.
- R12: Flags live at address 5 and are cleared by writing 1 to a bit. A set event in the same cycle wins over the clear. A compare match also sets the register's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start counting pulse |
| stop | input | 1 | Stop counting pulse |
| sw_reset | input | 1 | Zero the count pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 pin config, 2 count, 3 A, 4 B, 5 flags |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 16 | Read data, combinational |
| pin_in | input | 2 | Capture inputs, bit 0 pin A, bit 1 pin B |
| pin_out | output | 2 | Compare output levels |
| pin_oe | output | 2 | Output drive enables |
| running | output | 1 | Counter running |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 2 | Match/capture flags for A (bit 0) and B (bit 1) |
| wr_err | output | 1 | Refused count write flag |

## Verification
Writes to registers, the count, the start and stop pulses, compare matches and flag changes all appear on the outputs one clock after the edge that samples them. A capture appears three clocks after the pin changes. The bench steps a behavioural model on each rising edge and compares every output and the selected read word 1 ns later, so each result is checked in the cycle it is due. Directed checks of capture latency sample the count after the second edge and the flag and register after the third.

// File: rtl/cct_pkg.sv
// Shared encodings for the compare-capture timer channel: the register
// address map, the pin mode codes, the clear-source codes and helpers that
// decode a pin mode. Assumes a 4-bit mode field per pin.
package cct_pkg;

    localparam int RA_CTRL  = 0;
    localparam int RA_PIN   = 1;
    localparam int RA_COUNT = 2;
    localparam int RA_REG_A = 3;
    localparam int RA_REG_B = 4;
    localparam int RA_FLAGS = 5;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] PM_OFF      = 4'd0;
    localparam logic [MODE_W-1:0] PM_L_LOW    = 4'd1;
    localparam logic [MODE_W-1:0] PM_L_HIGH   = 4'd2;
    localparam logic [MODE_W-1:0] PM_L_TOG    = 4'd3;
    localparam logic [MODE_W-1:0] PM_H_LOW    = 4'd4;
    localparam logic [MODE_W-1:0] PM_H_HIGH   = 4'd5;
    localparam logic [MODE_W-1:0] PM_H_TOG    = 4'd6;
    localparam logic [MODE_W-1:0] PM_CAP_RISE = 4'd7;
    localparam logic [MODE_W-1:0] PM_CAP_FALL = 4'd8;
    localparam logic [MODE_W-1:0] PM_CAP_BOTH = 4'd9;

    localparam logic [1:0] CLR_NONE = 2'd0;
    localparam logic [1:0] CLR_A    = 2'd1;
    localparam logic [1:0] CLR_B    = 2'd2;

    function automatic logic mode_drives(input logic [MODE_W-1:0] m);
        return (m >= PM_L_LOW) && (m <= PM_H_TOG);
    endfunction

    function automatic logic mode_captures(input logic [MODE_W-1:0] m);
        return (m >= PM_CAP_RISE) && (m <= PM_CAP_BOTH);
    endfunction

    function automatic logic mode_init_level(input logic [MODE_W-1:0] m);
        return (m >= PM_H_LOW) && (m <= PM_H_TOG);
    endfunction

    function automatic logic mode_match_level(input logic [MODE_W-1:0] m,
                                              input logic cur);
        case (m)
            PM_L_LOW, PM_H_LOW:   return 1'b0;
            PM_L_HIGH, PM_H_HIGH: return 1'b1;
            PM_L_TOG, PM_H_TOG:   return ~cur;
            default:              return cur;
        endcase
    endfunction

endpackage

// File: rtl/cct_prescale.sv
// Prescaler: a free-running divider counter and tick selection.
// Assumes DIV_W is wide enough for the largest divisor (2^10).
module cct_prescale #(
    parameter int DIV_W = 10,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [1:0]       edge_sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] low_bits;
    int               shift;

    function automatic int sel_shift(input logic [SEL_W-1:0] s);
        if (s <= SEL_W'(6)) return int'(s);
        if (s == SEL_W'(7)) return 8;
        if (s == SEL_W'(8)) return 10;
        return 0;
    endfunction

    // Divider counter: counts system clocks from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // Tick select: rising, falling or both phases of the divided clock.
    always_comb begin
        shift    = sel_shift(div_sel);
        mask     = DIV_W'((32'd1 << shift) - 32'd1);
        low_bits = div_cnt & mask;
        if (shift == 0) begin
            tick = 1'b1;
        end else begin
            case (edge_sel)
                2'd0:    tick = (low_bits == mask);
                2'd1:    tick = (low_bits == (mask >> 1));
                default: tick = (low_bits == mask) || (low_bits == (mask >> 1));
            endcase
        end
    end

endmodule

// File: rtl/cct_capsync.sv
// Capture input conditioning: a synchroniser chain followed by an edge
// detector. Assumes the pin is asynchronous to clk.
module cct_capsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser shift and previous-value register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge decode on the synchronised level.
    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/cct_pin.sv
// One channel pin: holds the output level for compare modes and qualifies
// capture edges for capture modes. Assumes the mode input is registered.
module cct_pin
    import cct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] new_mode,
    input  logic              start_ev,
    input  logic              match_ev,
    input  logic              clear_ev,
    input  logic              running,
    input  logic              edge_rise,
    input  logic              edge_fall,
    output logic              cap_ev,
    output logic              pin_out,
    output logic              pin_oe
);

    logic level_q;

    // Output level: config write, start, own match, then counter clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        level_q <= 1'b0;
        else if (cfg_wr)   level_q <= mode_init_level(new_mode);
        else if (start_ev) level_q <= mode_init_level(mode);
        else if (match_ev) level_q <= mode_match_level(mode, level_q);
        else if (clear_ev) level_q <= mode_init_level(mode);
    end

    // Capture qualification by the selected polarity.
    always_comb begin
        case (mode)
            PM_CAP_RISE: cap_ev = running & edge_rise;
            PM_CAP_FALL: cap_ev = running & edge_fall;
            PM_CAP_BOTH: cap_ev = running & (edge_rise | edge_fall);
            default:     cap_ev = 1'b0;
        endcase
    end

    assign pin_oe  = mode_drives(mode);
    assign pin_out = level_q & pin_oe;

endmodule

// File: rtl/cct_cmpreg.sv
// One capture/compare register with its write buffer. A write while
// stopped loads both copies. A capture loads the active copy. A transfer
// event moves the buffer to the active copy.
module cct_cmpreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             running,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_ev,
    input  logic             xfer_ev,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] buf_q;

    // Buffer: takes every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (wr_hit) buf_q <= wr_data;
    end

    // Active value: direct load when stopped, capture, or buffered transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active <= '0;
        else if (wr_hit && !running)  active <= wr_data;
        else if (cap_ev)              active <= cnt;
        else if (xfer_ev)             active <= buf_q;
    end

endmodule

// File: rtl/cc_timer_chan.sv
// Compare-capture timer channel top: the register port, counter, clear
// logic, flags and the two pin channels. Assumes CNT_W >= 8, so the
// control and pin words fit the data bus.
module cc_timer_chan
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              sw_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [1:0]        pin_in,
    output logic [1:0]        pin_out,
    output logic [1:0]        pin_oe,
    output logic              running,
    output logic              ovf_flag,
    output logic [1:0]        match_flag,
    output logic              wr_err
);

    localparam int NUM_CH = 2;
    localparam int CFG_W  = NUM_CH * MODE_W;
    localparam int CTL_W  = 8;
    localparam int FLG_W  = 4;

    logic [CTL_W-1:0]              ctrl_q;
    logic [CFG_W-1:0]              pincfg_q;
    logic [CNT_W-1:0]              cnt_q;
    logic                          running_q;
    logic [FLG_W-1:0]              flags_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  act_vec;
    logic [NUM_CH-1:0]             match_ev;
    logic [NUM_CH-1:0]             cap_ev;
    logic [NUM_CH-1:0]             edge_rise;
    logic [NUM_CH-1:0]             edge_fall;
    logic                          tick;
    logic                          clr_ev;
    logic                          start_ev;
    logic                          hit_ctrl, hit_pin, hit_cnt, hit_flags;
    logic [1:0]                    clr_sel;
    logic [FLG_W-1:0]              flag_set;

    assign hit_ctrl  = wr_en && (wr_addr == ADDR_W'(RA_CTRL));
    assign hit_pin   = wr_en && (wr_addr == ADDR_W'(RA_PIN));
    assign hit_cnt   = wr_en && (wr_addr == ADDR_W'(RA_COUNT));
    assign hit_flags = wr_en && (wr_addr == ADDR_W'(RA_FLAGS));
    assign clr_sel   = ctrl_q[7:6];
    assign start_ev  = start && !running_q && !stop;

    cct_prescale #(.DIV_W(DIV_W), .SEL_W(4)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (ctrl_q[3:0]),
        .edge_sel (ctrl_q[5:4]),
        .tick     (tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [MODE_W-1:0] mode_i;
        logic              wr_hit_i;
        assign mode_i   = pincfg_q[i*MODE_W +: MODE_W];
        assign wr_hit_i = wr_en && (wr_addr == ADDR_W'(RA_REG_A + i));
        assign match_ev[i] = running_q && tick && !mode_captures(mode_i)
                             && (cnt_q == act_vec[i]);

        cct_capsync #(.SYNC_STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .rise  (edge_rise[i]),
            .fall  (edge_fall[i])
        );

        cct_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_i),
            .cfg_wr    (hit_pin),
            .new_mode  (wr_data[i*MODE_W +: MODE_W]),
            .start_ev  (start_ev),
            .match_ev  (match_ev[i]),
            .clear_ev  (clr_ev),
            .running   (running_q),
            .edge_rise (edge_rise[i]),
            .edge_fall (edge_fall[i]),
            .cap_ev    (cap_ev[i]),
            .pin_out   (pin_out[i]),
            .pin_oe    (pin_oe[i])
        );

        cct_cmpreg #(.CNT_W(CNT_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit_i),
            .running (running_q),
            .wr_data (wr_data),
            .cap_ev  (cap_ev[i]),
            .xfer_ev (match_ev[0] && !mode_captures(mode_i)),
            .cnt     (cnt_q),
            .active  (act_vec[i])
        );
    end

    // Clear source decode: a match or capture on the selected register.
    always_comb begin
        case (clr_sel)
            CLR_A:   clr_ev = match_ev[0] || cap_ev[0];
            CLR_B:   clr_ev = match_ev[1] || cap_ev[1];
            default: clr_ev = 1'b0;
        endcase
    end

    // Control and pin configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            pincfg_q <= '0;
        end else begin
            if (hit_ctrl) ctrl_q   <= wr_data[CTL_W-1:0];
            if (hit_pin)  pincfg_q <= wr_data[CFG_W-1:0];
        end
    end

    // Run state: stop wins over start.
    always_ff @(posedge clk) begin
        if (!rst_n)     running_q <= 1'b0;
        else if (stop)  running_q <= 1'b0;
        else if (start) running_q <= 1'b1;
    end

    // Counter: reset pulse, stopped writes, clear, then tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (sw_reset)                 cnt_q <= '0;
        else if (hit_cnt && !running_q)    cnt_q <= wr_data;
        else if (wr_en && !running_q && (wr_addr == ADDR_W'(RA_REG_A)))
                                           cnt_q <= '0;
        else if (clr_ev)                   cnt_q <= '0;
        else if (running_q && tick)        cnt_q <= cnt_q + 1'b1;
    end

    // Flag set events: overflow, A, B, refused count write.
    always_comb begin
        flag_set[0] = running_q && tick && (cnt_q == '1) && !clr_ev;
        flag_set[1] = match_ev[0] || cap_ev[0];
        flag_set[2] = match_ev[1] || cap_ev[1];
        flag_set[3] = hit_cnt && running_q;
    end

    // Sticky flags, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         flags_q <= '0;
        else if (hit_flags) flags_q <= flag_set | (flags_q & ~wr_data[FLG_W-1:0]);
        else                flags_q <= flag_set | flags_q;
    end

    // Read mux.
    always_comb begin
        case (rd_addr)
            ADDR_W'(RA_CTRL):  rd_data = CNT_W'(ctrl_q);
            ADDR_W'(RA_PIN):   rd_data = CNT_W'(pincfg_q);
            ADDR_W'(RA_COUNT): rd_data = cnt_q;
            ADDR_W'(RA_REG_A): rd_data = act_vec[0];
            ADDR_W'(RA_REG_B): rd_data = act_vec[1];
            ADDR_W'(RA_FLAGS): rd_data = CNT_W'(flags_q);
            default:           rd_data = '0;
        endcase
    end

    assign running    = running_q;
    assign ovf_flag   = flags_q[0];
    assign match_flag = flags_q[2:1];
    assign wr_err     = flags_q[3];

endmodule

// File: rtl/cct_checker.sv
// Assertion checker for the timer channel, bound to the top module.
module cct_checker #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              sw_reset,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick,
    input logic [CNT_W-1:0]  act_a,
    input logic [1:0]        clr_sel,
    input logic [3:0]        mode_a,
    input logic              wr_err,
    input logic              ovf_flag
);

    logic cnt_write_hit;
    logic a_is_capture;
    assign cnt_write_hit = wr_en && ((wr_addr == ADDR_W'(2)) || (wr_addr == ADDR_W'(3)));
    assign a_is_capture  = (mode_a >= 4'd7) && (mode_a <= 4'd9);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sw_reset && !cnt_write_hit) |=> $stable(cnt)); // R2

    AST_RUN_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && wr_addr == ADDR_W'(2)) |=> wr_err); // R10

    AST_SWRESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (cnt == '0)); // R10

    AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && clr_sel == 2'd1 && !a_is_capture && cnt == act_a && !sw_reset)
        |=> (cnt == '0)); // R4

    AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == '1)); // R5

endmodule

bind cc_timer_chan cct_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .sw_reset (sw_reset),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt      (cnt_q),
    .tick     (tick),
    .act_a    (act_vec[0]),
    .clr_sel  (ctrl_q[7:6]),
    .mode_a   (pincfg_q[3:0]),
    .wr_err   (wr_err),
    .ovf_flag (ovf_flag)
);

// File: tb/sim_cc_timer_chan.sv
// Bench: behavioural reference model stepped on each rising edge and
// compared 1 ns later, plus directed checks on the corner cases.
module sim_cc_timer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0, sw_reset = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = 3'd2;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  pin_in = '0, pin_out, pin_oe, match_flag;
    logic        running, ovf_flag, wr_err;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cc_timer_chan u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .sw_reset(sw_reset),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .running(running), .ovf_flag(ovf_flag), .match_flag(match_flag), .wr_err(wr_err)
    );

    // ---------------- reference model state ----------------
    int m_cnt, m_div, m_ctrl, m_pin, m_run, m_ovf, m_err;
    int m_act[2], m_buf[2], m_lvl[2], m_fl[2], m_s1[2], m_s2[2], m_prev[2];

    function automatic int f_shift(int s);
        if (s <= 6) return s;
        if (s == 7) return 8;
        if (s == 8) return 10;
        return 0;
    endfunction
    function automatic bit f_cap(int m);  return m >= 7 && m <= 9; endfunction
    function automatic bit f_drv(int m);  return m >= 1 && m <= 6; endfunction
    function automatic int f_init(int m); return (m >= 4 && m <= 6) ? 1 : 0; endfunction
    function automatic int f_mlvl(int m, int cur);
        if (m == 1 || m == 4) return 0;
        if (m == 2 || m == 5) return 1;
        if (m == 3 || m == 6) return 1 - cur;
        return cur;
    endfunction

    task automatic model_step();
        int sh, mask, low, es, csel, ncnt, wd, wa;
        int mode[2], nact[2];
        bit tick, r, f, clr, st_ev, ovf_set;
        bit cap[2], mt[2];
        wd = int'(wr_data);
        wa = wr_en ? int'(wr_addr) : -1;
        sh = f_shift(m_ctrl & 15);
        if (sh == 0) tick = 1;
        else begin
            mask = (1 << sh) - 1;
            low  = m_div & mask;
            es   = (m_ctrl >> 4) & 3;
            r = (low == mask);
            f = (low == (mask >> 1));
            tick = (es == 0) ? r : (es == 1) ? f : (r || f);
        end
        csel = (m_ctrl >> 6) & 3;
        for (int i = 0; i < 2; i++) begin
            mode[i] = (m_pin >> (4 * i)) & 15;
            r = m_s2[i] == 1 && m_prev[i] == 0;
            f = m_s2[i] == 0 && m_prev[i] == 1;
            cap[i] = m_run == 1 && ((mode[i] == 7 && r) || (mode[i] == 8 && f) || (mode[i] == 9 && (r || f)));
            mt[i]  = m_run == 1 && tick && !f_cap(mode[i]) && m_cnt == m_act[i];
        end
        clr = (csel == 1 && (mt[0] || cap[0])) || (csel == 2 && (mt[1] || cap[1]));
        st_ev = start && m_run == 0 && !stop;
        if (sw_reset) ncnt = 0;
        else if (wa == 2 && m_run == 0) ncnt = wd;
        else if (wa == 3 && m_run == 0) ncnt = 0;
        else if (clr) ncnt = 0;
        else if (m_run == 1 && tick) ncnt = (m_cnt + 1) & 16'hFFFF;
        else ncnt = m_cnt;
        ovf_set = m_run == 1 && tick && m_cnt == 65535 && !clr;
        for (int i = 0; i < 2; i++) begin
            if (wa == 3 + i && m_run == 0) nact[i] = wd;
            else if (cap[i]) nact[i] = m_cnt;
            else if (mt[0] && !f_cap(mode[i])) nact[i] = m_buf[i];
            else nact[i] = m_act[i];
            if (wa == 3 + i) m_buf[i] = wd;
            m_act[i] = nact[i];
            if (wa == 1) m_lvl[i] = f_init((wd >> (4 * i)) & 15);
            else if (st_ev) m_lvl[i] = f_init(mode[i]);
            else if (mt[i]) m_lvl[i] = f_mlvl(mode[i], m_lvl[i]);
            else if (clr) m_lvl[i] = f_init(mode[i]);
        end
        if (wa == 5) begin
            m_ovf = (wd & 1) ? 0 : m_ovf;
            m_fl[0] = (wd & 2) ? 0 : m_fl[0];
            m_fl[1] = (wd & 4) ? 0 : m_fl[1];
            m_err = (wd & 8) ? 0 : m_err;
        end
        if (ovf_set) m_ovf = 1;
        if (mt[0] || cap[0]) m_fl[0] = 1;
        if (mt[1] || cap[1]) m_fl[1] = 1;
        if (wa == 2 && m_run == 1) m_err = 1;
        m_cnt = ncnt;
        if (wa == 0) m_ctrl = wd & 255;
        if (wa == 1) m_pin = wd & 255;
        if (stop) m_run = 0; else if (start) m_run = 1;
        m_div = (m_div + 1) & 1023;
        for (int i = 0; i < 2; i++) begin
            m_prev[i] = m_s2[i];
            m_s2[i] = m_s1[i];
            m_s1[i] = int'(pin_in[i]);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_div = 0; m_ctrl = 0; m_pin = 0; m_run = 0; m_ovf = 0; m_err = 0;
        for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_buf[i] = 0; m_lvl[i] = 0; m_fl[i] = 0;
            m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        end
    endtask

    function automatic int model_rd(int a);
        case (a)
            0: return m_ctrl;
            1: return m_pin;
            2: return m_cnt;
            3: return m_act[0];
            4: return m_act[1];
            5: return m_ovf | (m_fl[0] << 1) | (m_fl[1] << 2) | (m_err << 3);
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // Per-cycle comparison 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            int a, po, oe;
            a = int'(rd_addr);
            po = 0; oe = 0;
            for (int i = 0; i < 2; i++) begin
                if (f_drv((m_pin >> (4 * i)) & 15)) begin
                    oe |= (1 << i);
                    po |= (m_lvl[i] << i);
                end
            end
            chk(a == 2 ? "R2 count" : (a == 3 || a == 4) ? "R8 register" : "R9 readback",
                int'(rd_data), model_rd(a));
            chk("R6 pin_out", int'(pin_out), po);
            chk("R6 pin_oe", int'(pin_oe), oe);
            chk("R12 flags", int'({wr_err, match_flag, ovf_flag}), model_rd(5));
            chk("R1 running", int'(running), m_run);
        end
    end

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask
    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask
    task automatic pulse_start();
        @(negedge clk); start = 1; @(negedge clk); start = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    endtask
    task automatic pulse_swrst();
        @(negedge clk); sw_reset = 1; @(negedge clk); sw_reset = 0;
    endtask
    task automatic rd_chk(string tag, int a, int exp);
        rd_addr = 3'(a); #1;
        chk(tag, int'(rd_data), exp);
        rd_addr = 3'd2;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int mx, c;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        rd_chk("R1 count", 2, 0);
        rd_chk("R1 reg A", 3, 0);
        rd_chk("R1 flags", 5, 0);
        chk("R1 pins", int'({pin_oe, pin_out}), 0);
        chk("R1 stopped", int'(running), 0);

        // R2 divide by 1, free running
        pulse_start();
        cyc(20);
        chk("R2 count div1", int'(rd_data), m_cnt);
        pulse_stop();
        // R2/R3 divide by 4, rising / falling / both
        wr(0, 8'h02); wr(2, 0); pulse_start(); cyc(40);
        chk("R3 rising div4", int'(rd_data), m_cnt);
        wr(0, 8'h12); cyc(40);
        chk("R3 falling div4", int'(rd_data), m_cnt);
        wr(0, 8'h22); cyc(40);
        chk("R3 both div4", int'(rd_data), m_cnt);
        wr(0, 8'h08); cyc(2200);
        chk("R2 div1024", int'(rd_data), m_cnt);
        pulse_stop();

        // PWM: clear on A, div1, pin A init-high toggle, pin B low then high
        wr(0, 8'h40);
        wr(1, 8'h26);
        chk("R7 init after cfg", int'(pin_out), 1);
        chk("R6 drive enables", int'(pin_oe), 3);
        wr(3, 9);
        wr(4, 5);
        pulse_swrst();
        pulse_start();
        cyc(50);
        wr(3, 5);
        rd_chk("R8 A still active", 3, 9);
        wr(4, 2);
        cyc(40);
        rd_chk("R8 A after match", 3, 5);
        rd_chk("R8 B after match", 4, 2);
        mx = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); #1;
            if (int'(rd_data) > mx) mx = int'(rd_data);
        end
        chk("R4 period max", mx, 5);
        pulse_stop();
        // R9 stopped write of A applies now and zeroes count; odd period
        wr(3, 6);
        rd_chk("R9 count zeroed", 2, 0);
        rd_chk("R9 A direct", 3, 6);
        wr(4, 3);
        rd_chk("R9 B direct", 4, 3);
        pulse_start();
        cyc(30);
        chk("R7 odd period pins", int'(pin_out), (m_lvl[1] << 1) | m_lvl[0]);
        // clear on B, pin B init-high high-on-match
        wr(0, 8'h80); wr(1, 8'h50); cyc(30);
        chk("R4 clear on B", int'(rd_data), m_cnt);

        // R10 count writes
        wr(2, 16'h4444);
        chk("R10 refused write flag", int'(wr_err), 1);
        pulse_stop();
        wr(2, 16'h1234);
        rd_chk("R10 stopped write", 2, 16'h1234);
        pulse_swrst();
        rd_chk("R10 sw_reset", 2, 0);
        wr(5, 15);
        rd_chk("R12 w1c all", 5, 0);

        // R5 overflow
        wr(0, 0); wr(1, 0);
        wr(2, 16'hFFF0);
        pulse_start();
        cyc(30);
        chk("R5 overflow flag", int'(ovf_flag), 1);
        chk("R5 wrapped count", int'(rd_data), m_cnt);
        pulse_stop();

        // R11 capture
        wr(1, 8'h97);
        wr(2, 0);
        wr(5, 15);
        pulse_start();
        cyc(10);
        @(negedge clk); pin_in[0] = 1;
        cyc(2);
        #1; c = int'(rd_data);
        chk("R11 flag not yet", int'(match_flag[0]), 0);
        cyc(1);
        chk("R11 flag at third edge", int'(match_flag[0]), 1);
        rd_chk("R11 captured count", 3, c);
        wr(5, 2);
        @(negedge clk); pin_in[0] = 0;
        cyc(6);
        chk("R11 wrong polarity ignored", int'(match_flag[0]), 0);
        wr(0, 8'h80);
        @(negedge clk); pin_in[1] = 1;
        cyc(3);
        rd_chk("R11 clear by capture", 2, 0);
        chk("R11 flag B", int'(match_flag[1]), 1);
        cyc(5);
        pulse_stop();
        cyc(3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule